// File: doc/BRIEF.md
# Ordered Dither for Reduced-Depth Panels

The block takes a stream of pixels carrying ten bits for each of the red, green and blue colours, plus a single alpha bit. It reduces every colour to the code width that the panel actually has, which is 5, 6, 7 or 8 bits and is set separately for each colour. Each emitted code is either the truncated value or the code just above it. The bits that truncation drops decide, against a 4x4 ordered threshold pattern, which of those two neighbours is sent. Over an area or over a run of frames, the mix of the two codes then approaches the full ten-bit level.

In spatial mode the threshold depends on where the pixel sits within its 4x4 tile. In temporal mode it depends only on a frame count, which cycles through four values. Both modes round only upward, and they stop at the largest code, so the output never wraps. A pixel whose alpha bit is low is plainly truncated. The alpha bit travels with the pixel to the output. Pixels enter and leave through valid/ready handshakes and carry start-of-frame and end-of-line markers. The result is registered once.

Top module: `pix_dither`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Width select encoding per colour: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The code is right-aligned in its 8-bit output, and the unused upper bits are 0.
- R3: Every output code equals the input shifted right by the dropped bit count k = 10 − width, or that value plus one. When the dropped bits are zero, the code is exactly the truncated value.
- R4: Spatial mode (`cfg_temporal`=0): left-align the dropped bits into a 5-bit value t. The upper code is chosen when t > 2·m. Here m is the entry at row (y mod 4), column (x mod 4) of the pattern whose rows are {0,8,2,10}, {12,4,14,6}, {3,11,1,9} and {15,7,13,5}.
- R5: Temporal mode (`cfg_temporal`=1): the same comparison is used, with m = 8·f[0] + 4·f[1], where f is the 2-bit frame count. After reset, f becomes 0 on the first start-of-frame and increases by one (mod 4) on each later one.
- R6: Rounding up never goes past the largest code of the selected width. An all-ones input gives the all-ones code.
- R7: A pixel with alpha 0 is truncated only. The output alpha equals the input alpha of the same pixel.
- R8: A pixel marked start-of-frame is at x=0, y=0. Each accepted pixel advances x by one. A pixel marked end-of-line makes the next pixel x=0 and advances y by one. Both markers may sit on the same pixel.
- R9: A pixel accepted on a clock edge appears on the output after that edge. `in_ready` is high whenever the output register is empty or being read. While `out_valid` is 1 and `out_ready` is 0, the output holds steady.
- R10: The three colours use their own width selects independently within the same pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is first of a frame |
| in_eol | input | 1 | Pixel is last of a line |
| in_r | input | 10 | Red input level |
| in_g | input | 10 | Green input level |
| in_b | input | 10 | Blue input level |
| in_alpha | input | 1 | Per-pixel dither enable, passed through |
| cfg_temporal | input | 1 | 0 spatial, 1 temporal threshold source |
| cfg_wsel_r | input | 2 | Red output width select |
| cfg_wsel_g | input | 2 | Green output width select |
| cfg_wsel_b | input | 2 | Blue output width select |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_r | output | 8 | Red code, right-aligned |
| out_g | output | 8 | Green code, right-aligned |
| out_b | output | 8 | Blue code, right-aligned |
| out_alpha | output | 1 | Alpha of the output pixel |

## Verification
Two events can land on the same beat. The first is a frame start coinciding with a line end. The bench provokes it with frames one pixel wide, where each pixel closes its line and the first also opens the frame. It then judges every code against a reference that holds its own x, y and frame count. The second is an output stall coinciding with a waiting new pixel. Random backpressure provokes it, and the bench checks that the held output stays unchanged and that no queued expectation is skipped or repeated. Aggregate tallies over a 4x4 tile and over four frames confirm that the mix ratio equals the dropped fraction.

// File: rtl/pix_dither_pkg.sv
package pix_dither_pkg;

    localparam int VW     = 10;          // virtual level width
    localparam int PW     = 8;           // widest physical code
    localparam int NCH    = 3;           // colour count
    localparam int TW     = 5;           // left-aligned threshold width
    localparam int MW     = 4;           // pattern entry width
    localparam int POS_W  = 2;           // tile coordinate width

    typedef enum logic [1:0] {
        WID5 = 2'd0,
        WID6 = 2'd1,
        WID7 = 2'd2,
        WID8 = 2'd3
    } wsel_e;

    typedef struct packed {
        logic                   alpha;
        logic [NCH-1:0][VW-1:0] lvl;
    } in_pix_t;

    typedef struct packed {
        logic                   alpha;
        logic [NCH-1:0][PW-1:0] code;
    } out_pix_t;

    // number of low bits discarded for a width select
    function automatic logic [2:0] drop_bits(wsel_e w);
        return 3'd5 - {1'b0, w};
    endfunction

    // 4x4 ordered threshold pattern
    function automatic logic [MW-1:0] tile_thr(logic [POS_W-1:0] x, logic [POS_W-1:0] y);
        logic [MW-1:0] v;
        case ({y, x})
            4'd0:  v = 4'd0;   4'd1:  v = 4'd8;   4'd2:  v = 4'd2;   4'd3:  v = 4'd10;
            4'd4:  v = 4'd12;  4'd5:  v = 4'd4;   4'd6:  v = 4'd14;  4'd7:  v = 4'd6;
            4'd8:  v = 4'd3;   4'd9:  v = 4'd11;  4'd10: v = 4'd1;   4'd11: v = 4'd9;
            4'd12: v = 4'd15;  4'd13: v = 4'd7;   4'd14: v = 4'd13;  default: v = 4'd5;
        endcase
        return v;
    endfunction

    // frame-sequence threshold: bit-reversed frame count, scaled by four
    function automatic logic [MW-1:0] frame_thr(logic [POS_W-1:0] f);
        return {f[0], f[1], 2'b00};
    endfunction

endpackage

// File: rtl/pix_dither_pos.sv
module pix_dither_pos
    import pix_dither_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             sof,
    input  logic             eol,
    output logic [POS_W-1:0] x_cur,
    output logic [POS_W-1:0] y_cur,
    output logic [POS_W-1:0] f_cur
);
    logic [POS_W-1:0] x_q, y_q, f_q;

    always_comb begin
        x_cur = sof ? '0 : x_q;
        y_cur = sof ? '0 : y_q;
        f_cur = sof ? POS_W'(f_q + 1'b1) : f_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
            f_q <= '1;               // first frame start lands on count 0
        end else if (fire) begin
            f_q <= f_cur;
            if (eol) begin
                x_q <= '0;
                y_q <= POS_W'(y_cur + 1'b1);
            end else begin
                x_q <= POS_W'(x_cur + 1'b1);
                y_q <= y_cur;
            end
        end
    end

    // R8: a line end restarts the column count for the next pixel
    a_r8_eol_restart: assert property (@(posedge clk) disable iff (rst)
        fire && eol |=> x_q == '0);

    // R8: a frame start without line end puts the next pixel at (1,0)
    a_r8_sof_origin: assert property (@(posedge clk) disable iff (rst)
        fire && sof && !eol |=> x_q == POS_W'(1) && y_q == '0);

endmodule

// File: rtl/pix_dither_chan.sv
module pix_dither_chan
    import pix_dither_pkg::*;
(
    input  logic [VW-1:0] lvl,
    input  wsel_e         wsel,
    input  logic          en,
    input  logic [MW-1:0] thr,
    output logic [PW-1:0] code
);
    logic [2:0]    k;
    logic [VW-1:0] trunc, frac, top_code;
    logic [TW-1:0] t_al;
    logic          up;

    always_comb begin
        k        = drop_bits(wsel);
        trunc    = lvl >> k;
        frac     = lvl & ((VW'(1) << k) - VW'(1));
        t_al     = TW'(frac << (3'd5 - k));
        top_code = {VW{1'b1}} >> k;
        up       = en && (t_al > {thr, 1'b0});
        code     = (up && trunc != top_code) ? PW'(trunc + VW'(1)) : PW'(trunc);
    end

    // R6: the code never exceeds the largest code of its width
    always_comb begin
        a_r6_no_wrap: assert (VW'(code) <= top_code);
    end

    // R3: the code is one of the two nearest physical codes
    always_comb begin
        a_r3_nearest: assert (VW'(code) == trunc || VW'(code) == VW'(trunc + VW'(1)));
    end

endmodule

// File: rtl/pix_dither.sv
module pix_dither
    import pix_dither_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [VW-1:0] in_r,
    input  logic [VW-1:0] in_g,
    input  logic [VW-1:0] in_b,
    input  logic          in_alpha,
    input  logic          cfg_temporal,
    input  logic [1:0]    cfg_wsel_r,
    input  logic [1:0]    cfg_wsel_g,
    input  logic [1:0]    cfg_wsel_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_r,
    output logic [PW-1:0] out_g,
    output logic [PW-1:0] out_b,
    output logic          out_alpha
);
    in_pix_t           pin;
    out_pix_t          pnext, pout_q;
    wsel_e [NCH-1:0]   wsel;
    logic [POS_W-1:0]  xc, yc, fc;
    logic [MW-1:0]     thr;
    logic              fire, ov_q;

    assign pin.alpha  = in_alpha;
    assign pin.lvl    = {in_b, in_g, in_r};
    assign wsel       = {wsel_e'(cfg_wsel_b), wsel_e'(cfg_wsel_g), wsel_e'(cfg_wsel_r)};
    assign in_ready   = !ov_q || out_ready;
    assign fire       = in_valid && in_ready;

    pix_dither_pos u_pos (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .sof   (in_sof),
        .eol   (in_eol),
        .x_cur (xc),
        .y_cur (yc),
        .f_cur (fc)
    );

    assign thr = cfg_temporal ? frame_thr(fc) : tile_thr(xc, yc);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            pix_dither_chan u_chan (
                .lvl  (pin.lvl[c]),
                .wsel (wsel[c]),
                .en   (pin.alpha),
                .thr  (thr),
                .code (pnext.code[c])
            );
        end
    endgenerate

    assign pnext.alpha = pin.alpha;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q   <= 1'b0;
            pout_q <= '0;
        end else begin
            if (in_ready) ov_q <= in_valid;
            if (fire)     pout_q <= pnext;
        end
    end

    assign out_valid = ov_q;
    assign out_r     = pout_q.code[0];
    assign out_g     = pout_q.code[1];
    assign out_b     = pout_q.code[2];
    assign out_alpha = pout_q.alpha;

    // R9: a stalled output stays put
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g)
                                    && $stable(out_b) && $stable(out_alpha));

    // R9: an accepted pixel is presented after one edge
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R7: alpha travels with its pixel
    a_r7_alpha_pass: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_alpha == $past(in_alpha));

    // R7: alpha low at 8-bit width gives the plain upper bits
    a_r7_truncate: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_alpha && cfg_wsel_r == 2'd3
        |=> out_r == $past(in_r[VW-1:VW-PW]));

endmodule

// File: tb/pix_dither_tb.sv
module pix_dither_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_alpha = 1'b0;
    logic [9:0] in_r = '0, in_g = '0, in_b = '0;
    logic       cfg_temporal = 1'b0;
    logic [1:0] cfg_wsel_r = 2'd1, cfg_wsel_g = 2'd1, cfg_wsel_b = 2'd1;
    logic       out_ready = 1'b1;
    logic       in_ready, out_valid, out_alpha;
    logic [7:0] out_r, out_g, out_b;

    always #2 clk = ~clk;   // 250 MHz

    pix_dither u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_eol(in_eol), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .in_alpha(in_alpha), .cfg_temporal(cfg_temporal), .cfg_wsel_r(cfg_wsel_r),
        .cfg_wsel_g(cfg_wsel_g), .cfg_wsel_b(cfg_wsel_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_alpha(out_alpha)
    );

    int n_chk = 0, n_bad = 0;
    logic [24:0] q_exp[$];
    string       q_tag[$];
    int bx = 0, by = 0, bf = 3;
    int pat[16] = '{0, 8, 2, 10, 12, 4, 14, 6, 3, 11, 1, 9, 15, 7, 13, 5};
    logic bp_en = 1'b0;
    logic tally_on = 1'b0;
    int   tally = 0;

    function automatic int model(int v, int w, bit en, int m);
        int k, tr, t, mx;
        k  = 5 - w;
        tr = v >> k;
        t  = (v % (1 << k)) << (5 - k);
        mx = (1 << (10 - k)) - 1;
        if (en && t > 2 * m && tr < mx) tr = tr + 1;
        return tr;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: compute expectation, present pixel, push when accepted
    task automatic send(int r, int g, int b, bit a, bit sof, bit eol, string tag);
        int m;
        logic [24:0] e;
        if (sof) begin bf = (bf + 1) % 4; bx = 0; by = 0; end
        m = cfg_temporal ? ((bf & 1) * 8 + (bf >> 1) * 4) : pat[(by % 4) * 4 + (bx % 4)];
        e = {a, 8'(model(b, cfg_wsel_b, a, m)), 8'(model(g, cfg_wsel_g, a, m)),
             8'(model(r, cfg_wsel_r, a, m))};
        if (eol) begin bx = 0; by = by + 1; end else bx = bx + 1;
        in_valid = 1'b1; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
        in_alpha = a; in_sof = sof; in_eol = eol;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(posedge clk); #1;
    endtask

    task automatic idle_drain();
        in_valid = 1'b0;
        while (q_exp.size() != 0) @(negedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(int w, int h, int seed, int amode, string tag);
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++) begin
                bit a;
                a = (amode == 0) ? 1'b1 : ((x + y) % 3 != 0);
                send((seed + x * 53 + y * 97) % 1024, (seed * 3 + x * 29 + y * 61) % 1024,
                     (seed * 7 + x * 71 + y * 13) % 1024, a, x == 0 && y == 0, x == w - 1, tag);
            end
    endtask

    // output backpressure pattern
    always @(posedge clk) begin
        #1 out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
    end

    // monitor: compare on transfer, check hold under stall
    logic        held_v = 1'b0;
    logic [24:0] held;
    always @(negedge clk) begin
        if (!rst) begin
            logic [24:0] act;
            act = {out_alpha, out_b, out_g, out_r};
            if (held_v && out_valid)
                check(act == held, "R9 hold", 32'(act), 32'(held));
            held_v = out_valid && !out_ready;
            held   = act;
            if (out_valid && out_ready) begin
                if (q_exp.size() == 0) check(1'b0, "R9 unexpected output", 32'(act), 0);
                else begin
                    logic [24:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(act == e, t, 32'(act), 32'(e));
                    if (tally_on) tally += int'(out_r);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
        @(posedge clk); #1;

        // spatial, all six-bit
        send_frame(8, 4, 5, 0, "R4 spatial 6-bit");
        idle_drain();

        // mixed widths incl. extremes and exact codes, with stalls
        bp_en = 1'b1;
        cfg_wsel_r = 2'd0; cfg_wsel_g = 2'd2; cfg_wsel_b = 2'd3;
        send(1023, 1023, 1023, 1'b1, 1'b1, 1'b0, "R6 all-ones saturates");
        send(1016, 1022, 1021, 1'b1, 1'b0, 1'b0, "R6 near top");
        send(0, 0, 0, 1'b1, 1'b0, 1'b0, "R3 zero level");
        send(64, 128, 256, 1'b1, 1'b0, 1'b1, "R3 exact codes");
        send_frame(6, 5, 211, 0, "R10 per-colour widths");
        send_frame(5, 4, 77, 1, "R7 alpha mix");
        idle_drain();

        // one-pixel-wide frames: start and line end on the same beat
        cfg_wsel_r = 2'd1; cfg_wsel_g = 2'd3; cfg_wsel_b = 2'd2;
        send_frame(1, 6, 333, 0, "R8 sof with eol");
        send_frame(3, 6, 901, 1, "R8 line stepping");
        idle_drain();
        bp_en = 1'b0;

        // spatial ratio: half fraction over one tile, 8-bit
        cfg_wsel_r = 2'd3; cfg_wsel_g = 2'd3; cfg_wsel_b = 2'd3;
        tally = 0; tally_on = 1'b1;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 4; x++)
                send(82, 82, 82, 1'b1, x == 0 && y == 0, x == 3, "R4 tile");
        idle_drain();
        tally_on = 1'b0;
        check(tally == 328, "R4 tile mix ratio", 32'(tally), 328);

        // temporal ratio: quarter fraction, four frames of 2x2
        cfg_temporal = 1'b1;
        tally = 0; tally_on = 1'b1;
        for (int f = 0; f < 4; f++)
            for (int p = 0; p < 4; p++)
                send(41, 41, 41, 1'b1, p == 0, p % 2 == 1, "R5 temporal");
        idle_drain();
        tally_on = 1'b0;
        check(tally == 164, "R5 frame mix ratio", 32'(tally), 164);

        // temporal with other widths and stalls
        bp_en = 1'b1;
        cfg_wsel_r = 2'd0; cfg_wsel_g = 2'd1; cfg_wsel_b = 2'd2;
        send_frame(4, 3, 19, 0, "R5 temporal widths");
        send_frame(4, 3, 555, 1, "R7 temporal alpha");
        send_frame(2, 2, 1000, 0, "R2 width codes");
        idle_drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule